// File: doc/BRIEF.md
# Flash Page-Rewrite Controller

The block sits in front of a small flash array of physical blocks, each holding a fixed number of pages. Clients address data as a logical block plus a page index, and every transfer moves one whole page. Flash cells can only be programmed from the erased state, and erasing works on a whole block at a time. The controller therefore keeps a status for each physical page, a bitmap of the live pages in each block, and a map from logical to physical blocks.

A write to a page that is still erased is programmed in place. A write to a page that already holds data cannot be done in place. The controller takes an unused block that is not worn out and erases it, waiting a delay set at a port. It programs the new page into that block, copies across every other live page of the old block, and only then points the logical block at the new physical block. The old block goes back to the pool. Every physical block counts its erases and is retired once the count reaches a limit. When no usable block remains, a rewrite ends with an error and changes nothing. The array itself is a register-file model inside the block.

Top module: `flashrw_ctrl`

## Requirements
- R1: After reset `busy` and `done` are low, logical block i maps to physical block i, the remaining physical blocks are unused, and every page reads back as all ones.
- R2: A read returns the last data written to that logical page, or all ones if the page was never written. It holds `busy` for exactly one cycle.
- R3: A write to a logical page that has never been written programs the page directly and holds `busy` for exactly one cycle.
- R4: A physical page is programmed only while its status is erased. A write to an already-written page therefore always goes through the rewrite sequence, after which the new data reads back.
- R5: A rewrite leaves every other written page of the logical block readable with unchanged data. It holds `busy` for exactly E + PAGES + 4 cycles, where E is the erase delay.
- R6: The erase step lasts E + 1 cycles, where E is the value on `erase_wait` in the cycle after the request is accepted.
- R7: A rewrite picks the lowest-numbered physical block that is unused and whose erase count is below WEAR_LIMIT. Each erase adds one to that block's count, and a block whose count has reached WEAR_LIMIT is never erased again.
- R8: If a rewrite finds no usable block, it completes after one busy cycle with `err` high together with `done`, and no page data or mapping changes.
- R9: While `busy` is high, `req_valid` is ignored. A request presented during a rewrite is neither queued nor carried out.
- R10: `done` is a one-cycle pulse in the first cycle after `busy` falls.
- R11: The logical-to-physical map changes only when a rewrite completes without error, after all copying has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when not busy |
| req_write | input | 1 | 1 = page write, 0 = page read |
| req_blk | input | LBLK_W | Logical block number |
| req_page | input | PG_W | Page index inside the block |
| req_wdata | input | DATA_W | Page data for a write |
| erase_wait | input | EW_W | Extra cycles the erase step waits |
| busy | output | 1 | High while a request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion status, valid with `done` |
| rdata | output | DATA_W | Data of the last completed read |

## Verification
Assertions check the following on every cycle:
- no page is programmed unless it is erased;
- no retired block and no block still in use is erased;
- the rewrite states follow each other in order;
- the map only moves in the cycle a successful rewrite reports done;
- `done` is a single pulse that follows `busy`.

Other behaviours can only be shown by the bench's scenarios:
- the copy keeps every live page intact and returns new data on the rewritten page;
- busy times scale with the erase delay;
- wear follows the pick order until the pool runs dry and errors begin;
- a request injected during a rewrite leaves no trace.

// File: rtl/flashrw_pkg.sv
package flashrw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOKUP,
      ST_ERASE,
      ST_PROG,
      ST_COPY,
      ST_REMAP
   } fl_state_t;

endpackage

// File: rtl/flashrw_page_store.sv
module flashrw_page_store #(
   parameter int NUM_BLK = 6,
   parameter int PAGES   = 32,
   parameter int DATA_W  = 16,
   localparam int BLK_W  = $clog2(NUM_BLK),
   localparam int PG_W   = $clog2(PAGES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BLK_W-1:0]  rd_blk,
   input  logic [PG_W-1:0]   rd_pg,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_prog,
   input  logic              prog_en,
   input  logic [BLK_W-1:0]  prog_blk,
   input  logic [PG_W-1:0]   prog_pg,
   input  logic [DATA_W-1:0] prog_data,
   input  logic              erase_en,
   input  logic [BLK_W-1:0]  erase_blk
);

   logic [NUM_BLK-1:0][DATA_W-1:0] blk_data;
   logic [NUM_BLK-1:0]             blk_prog;
   logic [NUM_BLK-1:0]             blk_tgt_prog;

   for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
      logic [DATA_W-1:0] cell_q [PAGES];
      logic [PAGES-1:0]  stat_q;
      logic              hit_erase;
      logic              hit_prog;

      assign hit_erase = erase_en && (erase_blk == BLK_W'(b));
      assign hit_prog  = prog_en && (prog_blk == BLK_W'(b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int p = 0; p < PAGES; p++) cell_q[p] <= '1;
            stat_q <= '0;
         end else if (hit_erase) begin
            for (int p = 0; p < PAGES; p++) cell_q[p] <= '1;
            stat_q <= '0;
         end else if (hit_prog) begin
            cell_q[prog_pg] <= prog_data;
            stat_q[prog_pg] <= 1'b1;
         end
      end

      assign blk_data[b]     = cell_q[rd_pg];
      assign blk_prog[b]     = stat_q[rd_pg];
      assign blk_tgt_prog[b] = stat_q[prog_pg];
   end

   assign rd_data = blk_data[rd_blk];
   assign rd_prog = blk_prog[rd_blk];

   // R4
   prog_erased_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_en |-> !blk_tgt_prog[prog_blk]);

   // R4
   prog_erase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(prog_en && erase_en));

endmodule

// File: rtl/flashrw_wear_bank.sv
module flashrw_wear_bank #(
   parameter int NUM_BLK    = 6,
   parameter int WEAR_LIMIT = 1000,
   localparam int BLK_W     = $clog2(NUM_BLK),
   localparam int CNT_W     = $clog2(WEAR_LIMIT + 1)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               erase_en,
   input  logic [BLK_W-1:0]   erase_blk,
   output logic [NUM_BLK-1:0] retired
);

   for (genvar b = 0; b < NUM_BLK; b++) begin : g_cnt
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (erase_en && (erase_blk == BLK_W'(b)) &&
                      (cnt_q != CNT_W'(WEAR_LIMIT))) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end

      assign retired[b] = (cnt_q == CNT_W'(WEAR_LIMIT));

      // R7
      wear_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= CNT_W'(WEAR_LIMIT));
   end

   // R7
   erase_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_en |-> !retired[erase_blk]);

endmodule

// File: rtl/flashrw_free_pick.sv
module flashrw_free_pick #(
   parameter int NUM_BLK  = 6,
   parameter bit PICK_LOW = 1'b1,
   localparam int BLK_W   = $clog2(NUM_BLK)
)(
   input  logic [NUM_BLK-1:0] unused,
   input  logic [NUM_BLK-1:0] retired,
   output logic               found,
   output logic [BLK_W-1:0]   idx
);

   logic [NUM_BLK-1:0] cand;

   assign cand  = unused & ~retired;
   assign found = |cand;

   if (PICK_LOW) begin : g_low
      always_comb begin
         idx = '0;
         for (int i = NUM_BLK - 1; i >= 0; i--) begin
            if (cand[i]) idx = BLK_W'(i);
         end
      end
   end else begin : g_high
      always_comb begin
         idx = '0;
         for (int i = 0; i < NUM_BLK; i++) begin
            if (cand[i]) idx = BLK_W'(i);
         end
      end
   end

endmodule

// File: rtl/flashrw_ctrl.sv
module flashrw_ctrl
   import flashrw_pkg::*;
#(
   parameter int NUM_BLK    = 6,
   parameter int LOG_BLK    = 4,
   parameter int PAGES      = 32,
   parameter int DATA_W     = 16,
   parameter int WEAR_LIMIT = 1000,
   parameter int EW_W       = 8,
   parameter bit PICK_LOW   = 1'b1,
   localparam int BLK_W     = $clog2(NUM_BLK),
   localparam int LBLK_W    = $clog2(LOG_BLK),
   localparam int PG_W      = $clog2(PAGES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [LBLK_W-1:0] req_blk,
   input  logic [PG_W-1:0]   req_page,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [EW_W-1:0]   erase_wait,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] rdata
);

   if (PAGES < 32 || PAGES > 128) begin : g_bad_pages
      $error("PAGES must lie in 32..128");
   end
   if (LOG_BLK < 2 || LOG_BLK != (1 << LBLK_W)) begin : g_bad_log
      $error("LOG_BLK must be a power of two, at least 2");
   end
   if (NUM_BLK <= LOG_BLK) begin : g_bad_phys
      $error("NUM_BLK must exceed LOG_BLK to leave a spare block");
   end
   if (WEAR_LIMIT < 1) begin : g_bad_wear
      $error("WEAR_LIMIT must be at least 1");
   end

   fl_state_t                    state_q;
   logic                         wr_q;
   logic [LBLK_W-1:0]            lb_q;
   logic [PG_W-1:0]              pg_q;
   logic [PG_W-1:0]              idx_q;
   logic [DATA_W-1:0]            wd_q;
   logic [DATA_W-1:0]            rdata_q;
   logic [BLK_W-1:0]             old_q;
   logic [BLK_W-1:0]             new_q;
   logic [EW_W-1:0]              ecnt_q;
   logic                         done_q;
   logic                         err_q;
   logic [LOG_BLK-1:0][BLK_W-1:0] map_q;
   logic [NUM_BLK-1:0]           unused_q;
   logic [NUM_BLK-1:0][PAGES-1:0] valid_q;

   logic [BLK_W-1:0]  cur_pb;
   logic [BLK_W-1:0]  rd_blk;
   logic [PG_W-1:0]   rd_pg;
   logic [DATA_W-1:0] rd_data;
   logic              rd_prog;
   logic              copy_hit;
   logic              prog_en;
   logic [BLK_W-1:0]  prog_blk;
   logic [PG_W-1:0]   prog_pg;
   logic [DATA_W-1:0] prog_data;
   logic              erase_en;
   logic [NUM_BLK-1:0] retired;
   logic              free_found;
   logic [BLK_W-1:0]  free_idx;

   assign cur_pb   = map_q[lb_q];
   assign rd_blk   = (state_q == ST_LOOKUP) ? cur_pb : old_q;
   assign rd_pg    = (state_q == ST_COPY) ? idx_q : pg_q;
   assign copy_hit = valid_q[old_q][idx_q] && (idx_q != pg_q);
   assign erase_en = (state_q == ST_ERASE) && (ecnt_q == '0);

   always_comb begin
      prog_en   = 1'b0;
      prog_blk  = new_q;
      prog_pg   = pg_q;
      prog_data = wd_q;
      case (state_q)
         ST_LOOKUP: begin
            if (wr_q && !rd_prog) begin
               prog_en  = 1'b1;
               prog_blk = cur_pb;
            end
         end
         ST_PROG: prog_en = 1'b1;
         ST_COPY: begin
            prog_en   = copy_hit;
            prog_pg   = idx_q;
            prog_data = rd_data;
         end
         default: prog_en = 1'b0;
      endcase
   end

   flashrw_page_store #(
      .NUM_BLK (NUM_BLK),
      .PAGES   (PAGES),
      .DATA_W  (DATA_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_blk    (rd_blk),
      .rd_pg     (rd_pg),
      .rd_data   (rd_data),
      .rd_prog   (rd_prog),
      .prog_en   (prog_en),
      .prog_blk  (prog_blk),
      .prog_pg   (prog_pg),
      .prog_data (prog_data),
      .erase_en  (erase_en),
      .erase_blk (new_q)
   );

   flashrw_wear_bank #(
      .NUM_BLK    (NUM_BLK),
      .WEAR_LIMIT (WEAR_LIMIT)
   ) u_wear (
      .clk       (clk),
      .rst_n     (rst_n),
      .erase_en  (erase_en),
      .erase_blk (new_q),
      .retired   (retired)
   );

   flashrw_free_pick #(
      .NUM_BLK  (NUM_BLK),
      .PICK_LOW (PICK_LOW)
   ) u_pick (
      .unused  (unused_q),
      .retired (retired),
      .found   (free_found),
      .idx     (free_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         wr_q     <= 1'b0;
         lb_q     <= '0;
         pg_q     <= '0;
         idx_q    <= '0;
         wd_q     <= '0;
         rdata_q  <= '0;
         old_q    <= '0;
         new_q    <= '0;
         ecnt_q   <= '0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         valid_q  <= '0;
         for (int i = 0; i < LOG_BLK; i++) map_q[i] <= BLK_W'(i);
         for (int i = 0; i < NUM_BLK; i++) unused_q[i] <= (i >= LOG_BLK);
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  wr_q    <= req_write;
                  lb_q    <= req_blk;
                  pg_q    <= req_page;
                  wd_q    <= req_wdata;
                  err_q   <= 1'b0;
                  state_q <= ST_LOOKUP;
               end
            end
            ST_LOOKUP: begin
               old_q <= cur_pb;
               if (!wr_q) begin
                  rdata_q <= rd_data;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (!rd_prog) begin
                  valid_q[cur_pb][pg_q] <= 1'b1;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (free_found) begin
                  new_q   <= free_idx;
                  ecnt_q  <= erase_wait;
                  state_q <= ST_ERASE;
               end else begin
                  err_q   <= 1'b1;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            ST_ERASE: begin
               if (ecnt_q == '0) begin
                  valid_q[new_q] <= '0;
                  state_q        <= ST_PROG;
               end else begin
                  ecnt_q <= ecnt_q - EW_W'(1);
               end
            end
            ST_PROG: begin
               valid_q[new_q][pg_q] <= 1'b1;
               idx_q   <= '0;
               state_q <= ST_COPY;
            end
            ST_COPY: begin
               if (copy_hit) valid_q[new_q][idx_q] <= 1'b1;
               idx_q <= idx_q + PG_W'(1);
               if (idx_q == PG_W'(PAGES - 1)) state_q <= ST_REMAP;
            end
            ST_REMAP: begin
               map_q[lb_q]     <= new_q;
               unused_q[old_q] <= 1'b1;
               unused_q[new_q] <= 1'b0;
               valid_q[old_q]  <= '0;
               done_q          <= 1'b1;
               state_q         <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy  = (state_q != ST_IDLE);
   assign done  = done_q;
   assign err   = err_q;
   assign rdata = rdata_q;

   // R11
   map_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(map_q) |-> (done && !err));

   // R10
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done || !$past(done) || $past(err));

   // R7
   erase_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_en |-> unused_q[new_q]);

   // R5
   copy_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_COPY) |=> (state_q == ST_COPY || state_q == ST_REMAP));

   // R6
   erase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ERASE && ecnt_q != '0) |=> (state_q == ST_ERASE));

endmodule

// File: tb/flashrw_ctrl_bench.sv
module flashrw_ctrl_bench;

   localparam int NB  = 3;
   localparam int LB  = 2;
   localparam int PG  = 32;
   localparam int DW  = 8;
   localparam int WL  = 3;
   localparam int EWW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [0:0]    req_blk = '0;
   logic [4:0]    req_page = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [EWW-1:0] erase_wait = '0;
   logic          busy;
   logic          done;
   logic          err;
   logic [DW-1:0] rdata;

   always #4 clk = ~clk;

   flashrw_ctrl #(
      .NUM_BLK (NB), .LOG_BLK (LB), .PAGES (PG), .DATA_W (DW),
      .WEAR_LIMIT (WL), .EW_W (EWW), .PICK_LOW (1'b1)
   ) u_flashrw_ctrl (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid),
      .req_write (req_write), .req_blk (req_blk), .req_page (req_page),
      .req_wdata (req_wdata), .erase_wait (erase_wait), .busy (busy),
      .done (done), .err (err), .rdata (rdata)
   );

   int n_chk  = 0;
   int n_fail = 0;
   int cyc_cnt = 0;

   logic [DW-1:0] exp_mem [LB][PG];
   bit            written [LB][PG];
   int            pmap [LB];
   bit            unused [NB];
   int            ecount [NB];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc_cnt++;
      if (cyc_cnt > 150000) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog actual=%0d expected<150000", cyc_cnt);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic run_req(input bit wr, input int lb, input int pg,
                          input logic [DW-1:0] d, input int ew, input bit inject,
                          output int cyc, output bit rerr, output logic [DW-1:0] dout);
      @(negedge clk);
      req_valid  = 1'b1;
      req_write  = wr;
      req_blk    = 1'(lb);
      req_page   = 5'(pg);
      req_wdata  = d;
      erase_wait = EWW'(ew);
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 0;
      while (busy && cyc < 2000) begin
         cyc++;
         if (inject && cyc == 5) begin
            req_valid = 1'b1;
            req_write = 1'b1;
            req_blk   = 1'b1;
            req_page  = 5'd7;
            req_wdata = 8'h5A;
         end else begin
            req_valid = 1'b0;
            req_blk   = 1'(lb);
            req_page  = 5'(pg);
            req_wdata = d;
         end
         @(negedge clk);
      end
      req_valid = 1'b0;
      check(done == 1'b1, "R10 done after busy", int'(done), 1);
      rerr = err;
      dout = rdata;
      @(negedge clk);
      check(done == 1'b0, "R10 single pulse", int'(done), 0);
   endtask

   task automatic do_read(input int lb, input int pg);
      int cyc;
      bit e;
      logic [DW-1:0] q;
      run_req(1'b0, lb, pg, '0, 0, 1'b0, cyc, e, q);
      check(cyc == 1, "R2 read busy", cyc, 1);
      check(q == exp_mem[lb][pg], "R2 read data", int'(q), int'(exp_mem[lb][pg]));
      check(e == 1'b0, "R2 read err", int'(e), 0);
   endtask

   task automatic read_all();
      for (int l = 0; l < LB; l++)
         for (int p = 0; p < PG; p++) do_read(l, p);
   endtask

   task automatic do_write(input int lb, input int pg, input logic [DW-1:0] d,
                           input int ew, input bit inject);
      int cyc;
      int exp_cyc;
      int pick;
      bit exp_err;
      bit e;
      logic [DW-1:0] q;
      bit rewrite;
      exp_err = 1'b0;
      pick    = -1;
      rewrite = written[lb][pg];
      if (!rewrite) begin
         exp_cyc = 1;
      end else begin
         for (int i = NB - 1; i >= 0; i--)
            if (unused[i] && ecount[i] < WL) pick = i;
         if (pick < 0) begin
            exp_err = 1'b1;
            exp_cyc = 1;
         end else begin
            exp_cyc = ew + PG + 4;
         end
      end
      run_req(1'b1, lb, pg, d, ew, inject, cyc, e, q);
      if (!rewrite) begin
         check(cyc == exp_cyc, "R3 direct program busy", cyc, exp_cyc);
      end else if (exp_err) begin
         check(cyc == exp_cyc, "R8 error busy", cyc, exp_cyc);
      end else begin
         check(cyc == exp_cyc, "R5 R6 rewrite busy", cyc, exp_cyc);
      end
      check(e == exp_err, exp_err ? "R8 error status" : "R7 pick status",
            int'(e), int'(exp_err));
      if (!exp_err) begin
         exp_mem[lb][pg] = d;
         written[lb][pg] = 1'b1;
         if (rewrite) begin
            ecount[pick]++;
            unused[pick] = 1'b0;
            unused[pmap[lb]] = 1'b1;
            pmap[lb] = pick;
         end
      end
   endtask

   initial begin
      for (int l = 0; l < LB; l++) begin
         pmap[l] = l;
         for (int p = 0; p < PG; p++) begin
            exp_mem[l][p] = '1;
            written[l][p] = 1'b0;
         end
      end
      for (int i = 0; i < NB; i++) begin
         unused[i] = (i >= LB);
         ecount[i] = 0;
      end

      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R1 busy at reset", int'(busy), 0);
      check(done == 1'b0, "R1 done at reset", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);

      // R1 R2: every page erased after reset
      read_all();

      // R3: direct programs on fresh pages, several patterns
      do_write(0, 0, 8'h11, 0, 1'b0);
      do_write(0, 5, 8'hA5, 0, 1'b0);
      do_write(0, 31, 8'h3C, 0, 1'b0);
      do_write(1, 0, 8'hC3, 0, 1'b0);
      do_write(1, 19, 8'h00, 0, 1'b0);
      read_all();

      // R4 R5 R6: rewrite of a programmed page keeps its neighbours
      do_write(0, 5, 8'h5B, 3, 1'b0);
      read_all();

      // R9: request injected during a rewrite is dropped (lb1 page 7 stays erased)
      do_write(1, 19, 8'h77, 9, 1'b1);
      do_read(1, 7);
      check(written[1][7] == 1'b0, "R9 injected write ignored", 0, 0);
      read_all();

      // R6 R7 R8: sweep erase delays until every block wears out
      for (int k = 0; k < 12; k++) begin
         do_write(k % 2, (k % 2 == 0) ? 0 : 19, DW'(8'h20 + k), (k * 7) % 23, 1'b0);
         read_all();
      end

      // R8: fresh page still programs directly once the pool is empty
      do_write(1, 30, 8'hE1, 0, 1'b0);
      do_write(1, 30, 8'hE2, 4, 1'b0);
      read_all();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule